// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address into a physical address. The first part, the segment selector, indexes a small on-chip table of segment descriptors. The second part, the displacement, is the offset into that segment. Each descriptor holds a physical base, a length, a stack-segment flag, three access-rights flags (read, write, execute) and a valid flag. Software loads descriptors one at a time through a write port.

Each request carries a selector, a displacement and an access kind. The unit fetches the descriptor and adds the displacement to the base. In the same cycle it checks the displacement against the length and checks the access kind against the stack flag and the rights. One cycle after a request is accepted, it returns either the physical address or a single fault code. When more than one check fails, the code reflects the highest-priority violation.

Top module: `seg_xlate_unit`

## Requirements
- R1: The selector indexes the descriptor table directly. A selector of 16 or above, or one that selects an entry whose valid flag is clear, yields fault code 1 (not present).
- R2: With no fault, the physical address equals descriptor base plus zero-extended displacement, truncated to 24 bits. A carry out of bit 23 is dropped silently.
- R3: A displacement greater than or equal to the descriptor length yields fault code 2 (limit).
- R4: On a segment whose stack flag is set, an access whose kind is not push (3) or pop (4) yields fault code 3 (type). Kind codes are read 0, write 1, fetch 2, push 3 and pop 4.
- R5: Read and pop need the read right. Write and push need the write right. Fetch needs the execute right. A missing right, or any kind code from 5 to 7, yields fault code 4 (rights).
- R6: When several checks fail, the code reported is the first in this order: not present (1), limit (2), type (3), rights (4).
- R7: rsp_fault is high exactly when rsp_code is nonzero. On a fault, rsp_paddr is zero.
- R8: rsp_valid is high in the cycle after a request is accepted (req_valid and req_ready both high) and low in every other cycle.
- R9: req_ready is low in any cycle where cfg_we is high, and high otherwise. A descriptor write is seen by every request accepted in a later cycle.
- R10: After reset, every descriptor is invalid and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_base | input | 24 | Segment physical base |
| cfg_len | input | 17 | Segment length in bytes (0 to 65536) |
| cfg_stack | input | 1 | Stack-segment flag |
| cfg_rd | input | 1 | Read right |
| cfg_wr | input | 1 | Write right |
| cfg_ex | input | 1 | Execute right |
| cfg_valid | input | 1 | Descriptor valid flag |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 5 | Segment selector |
| req_disp | input | 16 | Displacement within the segment |
| req_kind | input | 3 | Access kind code |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 3 | Fault code, 0 when there is no fault |
| rsp_paddr | output | 24 | Physical address, zero on a fault |

## Verification
Directed requests probe each check on its own. They cover a displacement one below and exactly at the length, all five access kinds on a stack segment and on a read-only segment, undefined kind codes, and selectors past the table. Further requests combine violations on one descriptor to separate the priority order from the individual checks. A base near the top of the physical range exposes the truncating add. Descriptor writes issued alongside requests, followed by long random mixes of writes and requests, show whether the stall and the write-then-use ordering hold.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      KIND_READ  = 3'd0,
      KIND_WRITE = 3'd1,
      KIND_FETCH = 3'd2,
      KIND_PUSH  = 3'd3,
      KIND_POP   = 3'd4
   } acc_kind_e;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ABSENT = 3'd1,
      FLT_LIMIT  = 3'd2,
      FLT_TYPE   = 3'd3,
      FLT_RIGHTS = 3'd4
   } flt_code_e;

   // right needed by an access kind; unknown kinds are never granted
   function automatic logic kind_permitted(input logic [2:0] kind,
                                           input logic r, input logic w,
                                           input logic x);
      case (kind)
         KIND_READ, KIND_POP:   return r;
         KIND_WRITE, KIND_PUSH: return w;
         KIND_FETCH:            return x;
         default:               return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/seg_desc_table.sv
`timescale 1ns/1ps
module seg_desc_table #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int PA_W    = 24,
   parameter int LEN_W   = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PA_W-1:0]  wr_base,
   input  logic [LEN_W-1:0] wr_len,
   input  logic             wr_stack,
   input  logic             wr_rd,
   input  logic             wr_wr,
   input  logic             wr_ex,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PA_W-1:0]  rd_base,
   output logic [LEN_W-1:0] rd_len,
   output logic             rd_stack,
   output logic             rd_rd,
   output logic             rd_wr,
   output logic             rd_ex,
   output logic             rd_valid
);

   if (ENTRIES > (1 << IDX_W)) begin : g_bad_depth
      $error("seg_desc_table: ENTRIES does not fit in IDX_W");
   end

   logic [PA_W-1:0]  base_q  [ENTRIES];
   logic [LEN_W-1:0] len_q   [ENTRIES];
   logic             stack_q [ENTRIES];
   logic             rd_q    [ENTRIES];
   logic             wr_q    [ENTRIES];
   logic             ex_q    [ENTRIES];
   logic             vld_q   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            len_q[e]   <= '0;
            stack_q[e] <= 1'b0;
            rd_q[e]    <= 1'b0;
            wr_q[e]    <= 1'b0;
            ex_q[e]    <= 1'b0;
            vld_q[e]   <= 1'b0;
         end else if (hit) begin
            base_q[e]  <= wr_base;
            len_q[e]   <= wr_len;
            stack_q[e] <= wr_stack;
            rd_q[e]    <= wr_rd;
            wr_q[e]    <= wr_wr;
            ex_q[e]    <= wr_ex;
            vld_q[e]   <= wr_valid;
         end
      end
   end

   logic in_table;
   if (ENTRIES == (1 << IDX_W)) begin : g_full_idx
      assign in_table = 1'b1;
   end else begin : g_part_idx
      assign in_table = (rd_idx < IDX_W'(ENTRIES));
   end

   always_comb begin
      rd_base  = '0;
      rd_len   = '0;
      rd_stack = 1'b0;
      rd_rd    = 1'b0;
      rd_wr    = 1'b0;
      rd_ex    = 1'b0;
      rd_valid = 1'b0;
      if (in_table) begin
         rd_base  = base_q[rd_idx];
         rd_len   = len_q[rd_idx];
         rd_stack = stack_q[rd_idx];
         rd_rd    = rd_q[rd_idx];
         rd_wr    = wr_q[rd_idx];
         rd_ex    = ex_q[rd_idx];
         rd_valid = vld_q[rd_idx];
      end
   end

endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W   = 5,
   parameter int ENTRIES = 16,
   parameter int DISP_W  = 16,
   parameter int PA_W    = 24,
   parameter int LEN_W   = 17
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [DISP_W-1:0] disp,
   input  logic [2:0]        kind,
   input  logic [PA_W-1:0]   d_base,
   input  logic [LEN_W-1:0]  d_len,
   input  logic              d_stack,
   input  logic              d_rd,
   input  logic              d_wr,
   input  logic              d_ex,
   input  logic              d_valid,
   output flt_code_e         code,
   output logic [PA_W-1:0]   paddr
);

   if (PA_W < DISP_W) begin : g_bad_pa
      $error("seg_check: PA_W narrower than DISP_W");
   end
   if (LEN_W != DISP_W + 1) begin : g_bad_len
      $error("seg_check: LEN_W must be DISP_W + 1");
   end

   logic sel_in_range;
   if (ENTRIES == (1 << SEL_W)) begin : g_sel_full
      assign sel_in_range = 1'b1;
   end else begin : g_sel_bound
      assign sel_in_range = (sel < SEL_W'(ENTRIES));
   end

   logic [LEN_W-1:0] disp_ext;
   logic             over_limit;
   logic             stack_op;
   logic             granted;
   logic [PA_W-1:0]  sum;

   assign disp_ext   = {1'b0, disp};
   assign over_limit = (disp_ext >= d_len);
   assign stack_op   = (kind == KIND_PUSH) || (kind == KIND_POP);
   assign granted    = kind_permitted(kind, d_rd, d_wr, d_ex);
   assign sum        = d_base + {{(PA_W-DISP_W){1'b0}}, disp};

   always_comb begin
      paddr = '0;
      if (!sel_in_range || !d_valid)  code = FLT_ABSENT;
      else if (over_limit)            code = FLT_LIMIT;
      else if (d_stack && !stack_op)  code = FLT_TYPE;
      else if (!granted)              code = FLT_RIGHTS;
      else begin
         code  = FLT_NONE;
         paddr = sum;
      end
   end

endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W   = 5,
   parameter int ENTRIES = 16,
   parameter int DISP_W  = 16,
   parameter int PA_W    = 24,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int LEN_W  = DISP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [PA_W-1:0]   cfg_base,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_stack,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic              cfg_ex,
   input  logic              cfg_valid,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [2:0]        req_kind,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [2:0]        rsp_code,
   output logic [PA_W-1:0]   rsp_paddr
);

   if (SEL_W < IDX_W) begin : g_bad_sel
      $error("seg_xlate_unit: selector narrower than table index");
   end
   if (ENTRIES < 2) begin : g_bad_ent
      $error("seg_xlate_unit: table needs at least two entries");
   end

   logic [PA_W-1:0]  d_base;
   logic [LEN_W-1:0] d_len;
   logic             d_stack, d_rd, d_wr, d_ex, d_valid;
   flt_code_e        chk_code;
   logic [PA_W-1:0]  chk_paddr;
   logic             accept;

   assign req_ready = !cfg_we;
   assign accept    = req_valid && req_ready;

   seg_desc_table #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .PA_W    (PA_W),
      .LEN_W   (LEN_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_base  (cfg_base),
      .wr_len   (cfg_len),
      .wr_stack (cfg_stack),
      .wr_rd    (cfg_rd),
      .wr_wr    (cfg_wr),
      .wr_ex    (cfg_ex),
      .wr_valid (cfg_valid),
      .rd_idx   (req_sel[IDX_W-1:0]),
      .rd_base  (d_base),
      .rd_len   (d_len),
      .rd_stack (d_stack),
      .rd_rd    (d_rd),
      .rd_wr    (d_wr),
      .rd_ex    (d_ex),
      .rd_valid (d_valid)
   );

   seg_check #(
      .SEL_W   (SEL_W),
      .ENTRIES (ENTRIES),
      .DISP_W  (DISP_W),
      .PA_W    (PA_W),
      .LEN_W   (LEN_W)
   ) u_check (
      .sel     (req_sel),
      .disp    (req_disp),
      .kind    (req_kind),
      .d_base  (d_base),
      .d_len   (d_len),
      .d_stack (d_stack),
      .d_rd    (d_rd),
      .d_wr    (d_wr),
      .d_ex    (d_ex),
      .d_valid (d_valid),
      .code    (chk_code),
      .paddr   (chk_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_code  <= FLT_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_fault <= (chk_code != FLT_NONE);
            rsp_code  <= chk_code;
            rsp_paddr <= chk_paddr;
         end
      end
   end

   // R7
   fault_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));

   // R7
   fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   // R8
   rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R8
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   // R9
   stall_on_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> !req_ready);

   // R6
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_code <= 3'd4));

endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

   localparam int SEL_W  = 5;
   localparam int ENT    = 16;
   localparam int IDX_W  = 4;
   localparam int DISP_W = 16;
   localparam int PA_W   = 24;
   localparam int LEN_W  = 17;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              cfg_we;
   logic [IDX_W-1:0]  cfg_idx;
   logic [PA_W-1:0]   cfg_base;
   logic [LEN_W-1:0]  cfg_len;
   logic              cfg_stack, cfg_rd, cfg_wr, cfg_ex, cfg_valid;
   logic              req_valid, req_ready;
   logic [SEL_W-1:0]  req_sel;
   logic [DISP_W-1:0] req_disp;
   logic [2:0]        req_kind;
   logic              rsp_valid, rsp_fault;
   logic [2:0]        rsp_code;
   logic [PA_W-1:0]   rsp_paddr;

   seg_xlate_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_len(cfg_len),
      .cfg_stack(cfg_stack), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_ex(cfg_ex),
      .cfg_valid(cfg_valid),
      .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
      .req_disp(req_disp), .req_kind(req_kind),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
      .rsp_paddr(rsp_paddr)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [PA_W-1:0]  m_base [ENT];
   logic [LEN_W-1:0] m_len  [ENT];
   bit m_stk [ENT];
   bit m_r [ENT];
   bit m_w [ENT];
   bit m_x [ENT];
   bit m_v [ENT];

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int code);
      case (code)
         0: return "R2";
         1: return "R1";
         2: return "R3";
         3: return "R4";
         default: return "R5";
      endcase
   endfunction

   // behavioural reference of one translation
   function automatic void model(input int s, input int d, input int k,
                                 output int code, output longint addr);
      bit ok;
      addr = 0;
      if (s >= ENT) begin code = 1; return; end
      if (!m_v[s]) begin code = 1; return; end
      if (k == 0 || k == 4)      ok = m_r[s];
      else if (k == 1 || k == 3) ok = m_w[s];
      else if (k == 2)           ok = m_x[s];
      else                       ok = 0;
      if (d >= int'(m_len[s]))               code = 2;
      else if (m_stk[s] && k != 3 && k != 4) code = 3;
      else if (!ok)                          code = 4;
      else begin
         code = 0;
         addr = (longint'(m_base[s]) + d) % (longint'(1) << PA_W);
      end
   endfunction

   // one clock: drive at negedge, check ready, then check the result one cycle on
   task automatic cyc(input bit we, input int idx, input int base, input int len,
                      input bit stk, input bit r, input bit w, input bit x, input bit v,
                      input bit rv, input int s, input int d, input int k,
                      input string tag);
      bit     e_valid;
      int     e_code;
      longint e_addr;
      cfg_we = we; cfg_idx = IDX_W'(idx); cfg_base = PA_W'(base); cfg_len = LEN_W'(len);
      cfg_stack = stk; cfg_rd = r; cfg_wr = w; cfg_ex = x; cfg_valid = v;
      req_valid = rv; req_sel = SEL_W'(s); req_disp = DISP_W'(d); req_kind = 3'(k);
      #1;
      check("R9", "req_ready", req_ready, !we);
      e_valid = rv && !we;
      e_code = 0; e_addr = 0;
      if (e_valid) model(s, d, k, e_code, e_addr);
      if (we) begin
         m_base[idx] = PA_W'(base); m_len[idx] = LEN_W'(len); m_stk[idx] = stk;
         m_r[idx] = r; m_w[idx] = w; m_x[idx] = x; m_v[idx] = v;
      end
      @(negedge clk);
      check("R8", "rsp_valid", rsp_valid, e_valid);
      if (e_valid) begin
         check(tag == "" ? tag_of(e_code) : tag, "rsp_code", rsp_code, e_code);
         check("R7", "rsp_fault", rsp_fault, e_code != 0);
         check(tag == "" ? tag_of(e_code) : tag, "rsp_paddr", rsp_paddr, e_addr);
      end
   endtask

   task automatic wr(input int idx, input int base, input int len, input bit stk,
                     input bit r, input bit w, input bit x, input bit v);
      cyc(1, idx, base, len, stk, r, w, x, v, 0, 0, 0, 0, "");
   endtask

   task automatic rq(input int s, input int d, input int k, input string tag = "");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, d, k, tag);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL R8 watchdog: actual hung expected done");
      summary();
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin
         m_base[i] = '0; m_len[i] = '0; m_stk[i] = 0;
         m_r[i] = 0; m_w[i] = 0; m_x[i] = 0; m_v[i] = 0;
      end
      rst_n = 1'b0;
      cfg_we = 0; cfg_idx = '0; cfg_base = '0; cfg_len = '0;
      cfg_stack = 0; cfg_rd = 0; cfg_wr = 0; cfg_ex = 0; cfg_valid = 0;
      req_valid = 0; req_sel = '0; req_disp = '0; req_kind = '0;
      repeat (3) @(negedge clk);
      check("R10", "rsp_valid in reset", rsp_valid, 0);
      check("R9", "req_ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "rsp_valid after reset", rsp_valid, 0);

      // every entry starts invalid
      for (int i = 0; i < ENT; i++) rq(i, 0, 0, "R10");

      // write while a request is offered: stalled, no result
      cyc(1, 0, 'h100000, 'h100, 0, 1, 1, 1, 1, 1, 0, 0, 0, "");
      rq(0, 'hFF, 0);
      rq(0, 'h100, 0);
      rq(0, 0, 2);

      // stack segment near top of physical space
      wr(1, 'hFFFF00, 'h10000, 1, 1, 1, 0, 1);
      rq(1, 'h200, 3);
      rq(1, 'hFFFF, 4);
      rq(1, 0, 2);
      rq(1, 0, 0);
      rq(1, 0, 1);

      // read-only ordinary segment
      wr(2, 'h040000, 'h20, 0, 1, 0, 0, 1);
      rq(2, 'h1F, 0);
      rq(2, 'h1F, 4);
      rq(2, 0, 1);
      rq(2, 0, 3);
      rq(2, 0, 2);
      rq(2, 0, 5);
      rq(2, 0, 7);

      // stack segment with no rights: priority cases
      wr(3, 'h000800, 4, 1, 0, 0, 0, 1);
      rq(3, 8, 2, "R6");
      rq(3, 0, 2, "R6");
      rq(3, 0, 3, "R6");
      rq(3, 3, 4, "R6");

      // invalid entry and out-of-range selectors
      wr(4, 'h123456, 0, 1, 0, 0, 0, 0);
      rq(4, 'hFFFF, 2, "R6");
      rq(16, 0, 0);
      rq(31, 0, 0);

      // full-length execute-only segment
      wr(5, 'h200000, 'h10000, 0, 0, 0, 1, 1);
      rq(5, 'hFFFF, 2);
      rq(5, 'hFFFF, 0);

      // rewrite takes effect for the next request
      wr(0, 'h300000, 'h10, 0, 0, 1, 0, 1);
      rq(0, 5, 1, "R9");
      rq(0, 5, 0, "R9");
      rq(0, 5, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int  len_pick;
         bit  we_pick;
         we_pick  = ($urandom_range(0, 9) == 0);
         len_pick = ($urandom_range(0, 3) == 0) ? 'h10000 : $urandom_range(0, 'h3FF);
         cyc(we_pick, $urandom_range(0, ENT - 1), $urandom_range(0, 'hFFFFFF), len_pick,
             $urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 4) != 0,
             $urandom_range(0, 3) != 0, $urandom_range(0, 19),
             $urandom_range(0, 1) ? $urandom_range(0, 'h3FF) : $urandom_range(0, 'hFFFF),
             $urandom_range(0, 7), "");
      end

      summary();
   end

endmodule